// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block decides when a memory-plus-logic device is in reset and when it may be used again. It watches an external active-low reset pin, a supply-good flag, a supply-lockout comparator flag and a busy flag from the flash controller. It produces the grant for memory access, a flash abort strobe, the flash read-mode state, a flash write inhibit and a flag that says whether the programmable-logic outputs can be trusted.

The first reset after the supply comes up is a cold reset and needs a long low pulse. Once a reset sequence has completed on a stable supply, later resets are warm and need only a short pulse. Low pulses shorter than the threshold that applies are ignored. After an accepted pulse is released, both kinds of reset share one recovery period before access is granted. If a flash program or erase is running when a reset is accepted, the block aborts it and forces read mode within a fixed bound. While the supply sits below the lockout level, flash writes are inhibited.

All outputs are registered on one clock. The reset pin passes through a two-flop synchronizer. `supply_good`, `supply_low` and `flash_busy` are assumed to be synchronous to `clk`. Every time constant is a parameter in clock cycles (defaults: cold 16, warm 4, recovery 8, abort 5, configuration load 6).

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_n` is low, the outputs settle to: `access_allowed`=0, `flash_abort`=0, `flash_read_mode`=1, `write_inhibit`=1, `outputs_valid`=0.
- R2: After a completed sequence (warm state), a synchronized low pulse of at least WARM_MIN_CYC cycles is accepted. A shorter pulse is ignored: `access_allowed` stays 1 and `flash_abort` stays 0.
- R3: In cold state, pulse width is counted only while `supply_good`=1. A pulse shorter than COLD_MIN_CYC is ignored, even when it exceeds WARM_MIN_CYC.
- R4: `access_allowed` rises exactly RECOVERY_CYC+3 rising clock edges after the pin is driven high, for both cold and warm resets. This is two synchronizer edges, one state update, then RECOVERY_CYC recovery cycles.
- R5: `flash_abort` is a one-cycle pulse. It is raised on the edge a reset is accepted, and only if `flash_busy`=1 at that edge.
- R6: `flash_read_mode` is 1 from reset. In normal operation it is the inverse of `flash_busy`, one cycle late. After an abort it stays 0 for ABORT_CYC cycles, counted from and including the abort pulse. It then returns to 1 and stays 1 until access is granted, even if `flash_busy` stays high.
- R7: `write_inhibit` is 1 whenever `access_allowed` is 0. While access is granted, it follows `supply_low` one cycle late.
- R8: `outputs_valid` rises CFG_LOAD_CYC edges after `supply_good` rises, and stays 1 throughout warm resets.
- R9: A low `supply_good` clears the warm state and drops `access_allowed` and `outputs_valid` on the next edge. The next reset is then treated as cold.
- R10: `access_allowed` falls on the edge a pulse is accepted. This is edge MIN+2 after the pin falls, where MIN is the threshold in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer logic |
| supply_good | input | 1 | Supply is stable at operating level |
| supply_low | input | 1 | Supply is below the write-lockout threshold |
| reset_pin_n | input | 1 | External active-low reset pin, asynchronous |
| flash_busy | input | 1 | Flash program or erase in progress |
| access_allowed | output | 1 | Memory access may proceed |
| flash_abort | output | 1 | One-cycle strobe terminating a flash program/erase |
| flash_read_mode | output | 1 | Flash is in read mode |
| write_inhibit | output | 1 | Flash write cycles must not start |
| outputs_valid | output | 1 | Logic outputs hold trustworthy values |

## Verification
Two situations are hardest to reach from the ports. One is a warm reset that arrives while a flash operation is busy. The other is a reset pulse whose width is exactly one cycle short of the threshold in force.

To reach the first, the stimulus completes a full cold power-up, raises `flash_busy`, and drives a pulse of exactly WARM_MIN_CYC cycles. It keeps `flash_busy` high past the abort window, so the forced return to read mode is observed while the busy flag still reads busy. It then clears `flash_busy` just before access returns.

To reach the second, the stimulus drops the supply to force cold state again. It then applies a COLD_MIN_CYC-1 pulse, which is longer than the warm threshold and must still be ignored. Finally it applies an exact COLD_MIN_CYC pulse, which must be accepted.

// File: rtl/rsq_pkg.sv
// Shared types for the reset sequencer.
package rsq_pkg;
    // Sequencer phases: waiting for a cold pulse, held in reset, recovering, running.
    typedef enum logic [1:0] {
        ST_COLD_WAIT = 2'd0,
        ST_HOLD      = 2'd1,
        ST_RECOVER   = 2'd2,
        ST_RUN       = 2'd3
    } rsq_state_e;
endpackage

// File: rtl/rsq_sync.sv
// Multi-flop synchronizer for an asynchronous level.
// Assumes STAGES >= 2. Resets to 0, which reads as an asserted active-low pin.
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_timer.sv
// Saturating up-counter with synchronous clear.
// reached is high once the count is at or above limit.
// Assumes the width can hold every limit given to it.
module rsq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] count;

    // Count up while enabled, stick at all-ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (clr)                   count <= '0;
        else if (en && (count != '1))   count <= count + 1'b1;
    end

    assign reached = (count >= limit);

    // R4: a clear always leaves the counter at zero on the next cycle
    a_r4_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/rsq_flash_guard.sv
// Flash-side reset effects: abort strobe, bounded abort window,
// read-mode state and write inhibit.
// Assumes accept_evt is a one-cycle event, and that run_d is the next-state "running" flag.
module rsq_flash_guard #(
    parameter int ABORT_CYC = 5,
    parameter int W         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_evt,
    input  logic flash_busy,
    input  logic run_d,
    input  logic supply_low,
    output logic flash_abort,
    output logic flash_read_mode,
    output logic write_inhibit
);
    logic pend_q;
    logic pend_d;
    logic ab_done;
    logic abort_d;

    assign abort_d = accept_evt && flash_busy;

    rsq_timer #(.W(W)) u_abort_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!pend_q),
        .en      (1'b1),
        .limit   (W'(ABORT_CYC - 1)),
        .reached (ab_done)
    );

    // Abort window opens on an abort and closes after ABORT_CYC cycles.
    always_comb begin
        pend_d = pend_q;
        if (abort_d)                  pend_d = 1'b1;
        else if (pend_q && ab_done)   pend_d = 1'b0;
    end

    // Register the abort window and all flash-facing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q          <= 1'b0;
            flash_abort     <= 1'b0;
            flash_read_mode <= 1'b1;
            write_inhibit   <= 1'b1;
        end else begin
            pend_q          <= pend_d;
            flash_abort     <= abort_d;
            flash_read_mode <= !pend_d && !(run_d && flash_busy);
            write_inhibit   <= !run_d || supply_low;
        end
    end

    // R5: the abort strobe never lasts two cycles
    a_r5_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        flash_abort |=> !flash_abort);

    // R6: read mode is left while the abort strobe is up
    a_r6_abort_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        flash_abort |-> !flash_read_mode);
endmodule

// File: rtl/rst_sequencer.sv
// Cold/warm reset sequencer.
// Qualifies reset-pin pulses against a cold or warm minimum width and enforces a shared recovery period.
// It also drives flash abort, read mode and write lockout, and flags valid logic outputs.
// Assumes supply_good, supply_low and flash_busy are synchronous to clk, and every *_CYC parameter is >= 1.
module rst_sequencer
    import rsq_pkg::*;
#(
    parameter int COLD_MIN_CYC  = 16,
    parameter int WARM_MIN_CYC  = 4,
    parameter int RECOVERY_CYC  = 8,
    parameter int ABORT_CYC     = 5,
    parameter int CFG_LOAD_CYC  = 6,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    input  logic supply_low,
    input  logic reset_pin_n,
    input  logic flash_busy,
    output logic access_allowed,
    output logic flash_abort,
    output logic flash_read_mode,
    output logic write_inhibit,
    output logic outputs_valid
);
    localparam int MAX_A   = (COLD_MIN_CYC > WARM_MIN_CYC) ? COLD_MIN_CYC : WARM_MIN_CYC;
    localparam int MAX_B   = (RECOVERY_CYC > ABORT_CYC) ? RECOVERY_CYC : ABORT_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > CFG_LOAD_CYC) ? MAX_C : CFG_LOAD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    rsq_state_e state_q, state_d;
    logic       warm_q, warm_d;
    logic       pin_s, pin_low;
    logic       lo_hit, rec_hit, cfg_hit;
    logic       accept_evt;
    logic [CNT_W-1:0] lo_limit;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (reset_pin_n),
        .q     (pin_s)
    );

    assign pin_low  = !pin_s;
    assign lo_limit = (state_q == ST_RUN) ? CNT_W'(WARM_MIN_CYC - 1)
                                          : CNT_W'(COLD_MIN_CYC - 1);

    rsq_timer #(.W(CNT_W)) u_low_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!pin_low || !supply_good),
        .en      (pin_low),
        .limit   (lo_limit),
        .reached (lo_hit)
    );

    rsq_timer #(.W(CNT_W)) u_recovery_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != ST_RECOVER),
        .en      (1'b1),
        .limit   (CNT_W'(RECOVERY_CYC - 1)),
        .reached (rec_hit)
    );

    rsq_timer #(.W(CNT_W)) u_cfg_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!supply_good),
        .en      (1'b1),
        .limit   (CNT_W'(CFG_LOAD_CYC - 1)),
        .reached (cfg_hit)
    );

    // Next phase: supply loss overrides everything, else qualify and time the pulse.
    always_comb begin
        state_d = state_q;
        if (!supply_good) begin
            state_d = ST_COLD_WAIT;
        end else begin
            case (state_q)
                ST_COLD_WAIT, ST_RUN: if (pin_low && lo_hit) state_d = ST_HOLD;
                ST_HOLD:              if (!pin_low) state_d = ST_RECOVER;
                ST_RECOVER: begin
                    if (pin_low)      state_d = ST_HOLD;
                    else if (rec_hit) state_d = ST_RUN;
                end
                default:              state_d = ST_COLD_WAIT;
            endcase
        end
    end

    // Warm state is earned by finishing recovery and lost with the supply.
    always_comb begin
        if (!supply_good)                                      warm_d = 1'b0;
        else if (state_q == ST_RECOVER && state_d == ST_RUN)   warm_d = 1'b1;
        else                                                   warm_d = warm_q;
    end

    assign accept_evt = (state_q == ST_COLD_WAIT || state_q == ST_RUN) && (state_d == ST_HOLD);

    // Register phase, warm flag and the access/validity outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_COLD_WAIT;
            warm_q         <= 1'b0;
            access_allowed <= 1'b0;
            outputs_valid  <= 1'b0;
        end else begin
            state_q        <= state_d;
            warm_q         <= warm_d;
            access_allowed <= (state_d == ST_RUN);
            outputs_valid  <= warm_d || (supply_good && cfg_hit);
        end
    end

    rsq_flash_guard #(.ABORT_CYC(ABORT_CYC), .W(CNT_W)) u_flash_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .accept_evt      (accept_evt),
        .flash_busy      (flash_busy),
        .run_d           (state_d == ST_RUN),
        .supply_low      (supply_low),
        .flash_abort     (flash_abort),
        .flash_read_mode (flash_read_mode),
        .write_inhibit   (write_inhibit)
    );

    // R7: no access without write inhibit
    a_r7_inhibit_without_access: assert property (@(posedge clk) disable iff (!rst_n)
        !access_allowed |-> write_inhibit);

    // R9: supply loss removes access and validity on the next edge
    a_r9_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good |=> (!access_allowed && !outputs_valid));

    // R4: access is granted only at the end of recovery
    a_r4_grant_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_allowed) |-> ($past(state_q) == ST_RECOVER));

    // R2: running implies the warm state has been earned
    a_r2_run_is_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> warm_q);

    // R10: an accepted warm pulse removes access on the next edge
    a_r10_access_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_good && state_q == ST_RUN && pin_low && lo_hit) |=> !access_allowed);
endmodule

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
    localparam int COLD = 16;
    localparam int WARM = 4;
    localparam int RECOV = 8;
    localparam int ABRT = 5;
    localparam int CFG = 6;

    localparam int S_ACC = 0, S_ABT = 1, S_RD = 2, S_INH = 3, S_VAL = 4;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_good = 1'b0;
    logic supply_low = 1'b0;
    logic reset_pin_n = 1'b0;
    logic flash_busy = 1'b0;
    logic access_allowed, flash_abort, flash_read_mode, write_inhibit, outputs_valid;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    rst_sequencer #(
        .COLD_MIN_CYC (COLD),
        .WARM_MIN_CYC (WARM),
        .RECOVERY_CYC (RECOV),
        .ABORT_CYC    (ABRT),
        .CFG_LOAD_CYC (CFG),
        .SYNC_STAGES  (2)
    ) u_rst_sequencer (
        .clk             (clk),
        .rst_n           (rst_n),
        .supply_good     (supply_good),
        .supply_low      (supply_low),
        .reset_pin_n     (reset_pin_n),
        .flash_busy      (flash_busy),
        .access_allowed  (access_allowed),
        .flash_abort     (flash_abort),
        .flash_read_mode (flash_read_mode),
        .write_inhibit   (write_inhibit),
        .outputs_valid   (outputs_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic get_sig(int s);
        case (s)
            S_ACC:   return access_allowed;
            S_ABT:   return flash_abort;
            S_RD:    return flash_read_mode;
            S_INH:   return write_inhibit;
            default: return outputs_valid;
        endcase
    endfunction

    function automatic string sig_name(int s);
        case (s)
            S_ACC:   return "access_allowed";
            S_ABT:   return "flash_abort";
            S_RD:    return "flash_read_mode";
            S_INH:   return "write_inhibit";
            default: return "outputs_valid";
        endcase
    endfunction

    task automatic check(string req, int s, logic exp);
        logic act;
        act = get_sig(s);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, sig_name(s), cyc, act, exp);
        end
    endtask

    // Driver side: schedule an expectation dly edges from now.
    task automatic expect_at(int dly, int s, logic v, string req);
        exp_t e;
        e.at = cyc + dly;
        e.sig = s;
        e.val = v;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due expectations away from the active edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(sb[i].req, sb[i].sig, sb[i].val);
                sb.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick(3);
        // R1 reset state
        check("R1", S_ACC, 1'b0);
        check("R1", S_ABT, 1'b0);
        check("R1", S_RD, 1'b1);
        check("R1", S_INH, 1'b1);
        check("R1", S_VAL, 1'b0);
        rst_n = 1'b1;
        tick(4);
        // R3: no counting without supply, R8: not valid yet
        check("R3", S_ACC, 1'b0);
        check("R8", S_VAL, 1'b0);

        // Cold power-up: supply rises with the pin already low
        supply_good = 1'b1;
        expect_at(CFG - 1, S_VAL, 1'b0, "R8");
        expect_at(CFG, S_VAL, 1'b1, "R8");
        tick(COLD + 4);
        reset_pin_n = 1'b1;
        expect_at(RECOV + 2, S_ACC, 1'b0, "R4");
        expect_at(RECOV + 3, S_ACC, 1'b1, "R4");
        expect_at(RECOV + 2, S_INH, 1'b1, "R7");
        expect_at(RECOV + 3, S_INH, 1'b0, "R7");
        expect_at(RECOV + 3, S_RD, 1'b1, "R6");
        tick(RECOV + 8);

        // R2: warm pulse one cycle short is ignored
        for (int k = 1; k <= WARM + RECOV + 6; k++) begin
            expect_at(k, S_ACC, 1'b1, "R2");
            expect_at(k, S_ABT, 1'b0, "R2");
        end
        reset_pin_n = 1'b0;
        tick(WARM - 1);
        reset_pin_n = 1'b1;
        tick(RECOV + 10);

        // R7: lockout gates writes while running
        supply_low = 1'b1;
        expect_at(1, S_INH, 1'b1, "R7");
        expect_at(1, S_ACC, 1'b1, "R7");
        tick(3);
        supply_low = 1'b0;
        expect_at(1, S_INH, 1'b0, "R7");
        tick(3);

        // R5/R6/R10: exact warm pulse during a busy flash operation
        flash_busy = 1'b1;
        expect_at(1, S_RD, 1'b0, "R6");
        tick(2);
        expect_at(WARM + 1, S_ACC, 1'b1, "R10");
        expect_at(WARM + 2, S_ACC, 1'b0, "R10");
        expect_at(WARM + 2, S_ABT, 1'b1, "R5");
        expect_at(WARM + 3, S_ABT, 1'b0, "R5");
        expect_at(WARM + 2 + ABRT - 1, S_RD, 1'b0, "R6");
        expect_at(WARM + 2 + ABRT, S_RD, 1'b1, "R6");
        expect_at(WARM + 2, S_VAL, 1'b1, "R8");
        expect_at(WARM + 3, S_VAL, 1'b1, "R8");
        expect_at(WARM + 2, S_INH, 1'b1, "R7");
        reset_pin_n = 1'b0;
        tick(WARM);
        reset_pin_n = 1'b1;
        expect_at(RECOV + 2, S_ACC, 1'b0, "R4");
        expect_at(RECOV + 3, S_ACC, 1'b1, "R4");
        expect_at(RECOV + 2, S_VAL, 1'b1, "R8");
        tick(ABRT + 3);
        flash_busy = 1'b0;
        tick(RECOV + 6);
        check("R6", S_RD, 1'b1);

        // R9: supply loss forces cold state
        supply_good = 1'b0;
        expect_at(1, S_ACC, 1'b0, "R9");
        expect_at(1, S_VAL, 1'b0, "R9");
        expect_at(1, S_INH, 1'b1, "R9");
        tick(2);
        supply_good = 1'b1;
        expect_at(CFG - 1, S_VAL, 1'b0, "R8");
        expect_at(CFG, S_VAL, 1'b1, "R8");
        tick(CFG + 2);

        // R3/R9: pulse above warm but one short of cold is ignored
        reset_pin_n = 1'b0;
        tick(COLD - 1);
        reset_pin_n = 1'b1;
        expect_at(RECOV + 3, S_ACC, 1'b0, "R3");
        expect_at(RECOV + 5, S_ACC, 1'b0, "R9");
        tick(RECOV + 8);

        // R3/R4: exact cold pulse is accepted
        reset_pin_n = 1'b0;
        tick(COLD);
        reset_pin_n = 1'b1;
        expect_at(RECOV + 2, S_ACC, 1'b0, "R4");
        expect_at(RECOV + 3, S_ACC, 1'b1, "R3");
        tick(RECOV + 8);

        if (sb.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule